// File: doc/BRIEF.md
# Clock Ratio Detector and Sync Monitor

This block sits in the system-clock domain of an audio converter. It watches the word clock (one cycle per audio sample) and counts how many system-clock cycles fit into each word period. Each measured period is classified as 256, 384 or 512 times the sample rate, or as invalid. Two consecutive periods with the same valid class lock the block to that ratio. The block then produces a clock enable that fires 256 times per word period, and downstream filter and modulator logic runs from that enable. The word clock may take any phase relative to the system clock. Only the count per period matters.

While locked, the block counts the enables that fall into each word period and compares the count with 256. One bit clock is taken as 4 enable ticks, which corresponds to 64 bit clocks per frame. A small drift is tolerated. A larger drift drops the lock. The block then mutes the data path and acquires the ratio again. After each lock, the mute request stays high for a fixed number of word periods before normal data may flow.

Top module: `clk_ratio_sync_mon`

## Requirements
- R1: A measured word period of N system-clock cycles is classified as 256x (code 2'b01), 384x (code 2'b10) or 512x (code 2'b11) when N lies within ±2 of 256, 384 or 512. Any other N gives code 2'b00 (invalid). While unlocked, `ratio_o` shows the class of the latest measured period.
- R2: The first word-clock rising edge after reset only starts a measurement. The block locks at the edge that closes the second consecutive period of the same valid class. While locked, `ratio_o` holds the locked class.
- R3: While locked, `en256_o` pulses 256 times per word period. It is high every cycle at 256x, on alternate cycles at 512x, and on two of every three cycles at 384x. The pattern restarts at each word-clock rising edge. While unlocked, `en256_o` stays low.
- R4: `mute_o` is high whenever `locked_o` is low. After a lock, `mute_o` stays high until the 32nd word-clock rising edge that follows the locking edge.
- R5: While locked, a period whose enable count differs from 256 by at most 20 ticks (5 bit clocks) keeps the lock and does not mute.
- R6: While locked, an enable count that differs from 256 by more than 24 ticks (6 bit clocks) drops the lock and asserts `mute_o`. A long period is caught as soon as the running count passes 280, before that period ends. A short period is caught at its closing edge.
- R7: After a loss of lock, the block acquires again under the two-period rule, taking the new ratio if the ratio has changed. The 32-period mute of R4 applies again.
- R8: While reset is asserted and after its release, `ratio_o` is 2'b00, `locked_o` is 0, `mute_o` is 1 and `en256_o` is 0.
- R9: A word clock whose period fits no valid class never locks. It keeps `mute_o` high and `en256_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word clock, sampled in the system-clock domain |
| ratio_o | output | 2 | Ratio code: 00 invalid, 01 256x, 10 384x, 11 512x |
| en256_o | output | 1 | Clock enable at 256 times the sample rate |
| locked_o | output | 1 | Ratio locked and word clock in sync |
| mute_o | output | 1 | Request to force output data to zero |

## Verification
Two situations are hard to reach from the ports: a loss of lock while the block is already unmuted, and the release of the mute after it. To get there, the stimulus first runs enough clean word periods to pass the full 32-period mute. It then stretches or shrinks a single word period by a chosen number of cycles. One change stays inside the tolerance, and the others fall beyond it on the long side and on the short side. A long period must be flagged before it ends, so it is checked at its own last cycle. The count of clean periods until the mute clears again is checked against the relock rule. A jump from 256x to 512x exercises acquisition of a changed ratio.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

  typedef enum logic [1:0] {
    RATIO_NONE = 2'b00,
    RATIO_256  = 2'b01,
    RATIO_384  = 2'b10,
    RATIO_512  = 2'b11
  } ratio_e;

  typedef enum logic [1:0] {
    ST_ACQ  = 2'b00,
    ST_HOLD = 2'b01,
    ST_RUN  = 2'b10
  } sync_st_e;

  function automatic logic near(input logic [31:0] len, input logic [31:0] ref_len,
                                input logic [31:0] tol);
    return (len + tol >= ref_len) && (len <= ref_len + tol);
  endfunction

  function automatic ratio_e classify(input logic [31:0] len, input logic [31:0] base,
                                      input logic [31:0] tol);
    logic [31:0] r384;
    logic [31:0] r512;
    r384 = base + (base >> 1);
    r512 = base << 1;
    if (near(len, base, tol))      return RATIO_256;
    else if (near(len, r384, tol)) return RATIO_384;
    else if (near(len, r512, tol)) return RATIO_512;
    else                           return RATIO_NONE;
  endfunction

endpackage

// File: rtl/wclk_meter.sv
module wclk_meter #(
  parameter int SYNC_N = 2,
  parameter int CNT_W  = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wclk_i,
  output logic             edge_o,
  output logic             meas_vld_o,
  output logic [CNT_W-1:0] meas_len_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_N-1:0] sync_q;
  logic              last_q;
  logic              seen_q;
  logic [CNT_W-1:0]  cnt_q;

  assign edge_o     = sync_q[SYNC_N-1] & ~last_q;
  assign meas_vld_o = edge_o & seen_q;
  assign meas_len_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
      seen_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], wclk_i};
      last_q <= sync_q[SYNC_N-1];
      if (edge_o) begin
        cnt_q  <= '0;
        seen_q <= 1'b1;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/clk_en_gen.sv
module clk_en_gen
  import clkmon_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   edge_i,
  input  logic   run_i,
  input  ratio_e mode_i,
  output logic   en_o
);

  logic [1:0] ph_q;

  // phase restarts on each word edge so every period carries an exact tick count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else if (edge_i) begin
      ph_q <= '0;
    end else begin
      unique case (mode_i)
        RATIO_384: ph_q <= (ph_q == 2'd2) ? 2'd0 : ph_q + 2'd1;
        RATIO_512: ph_q <= {1'b0, ~ph_q[0]};
        default:   ph_q <= '0;
      endcase
    end
  end

  always_comb begin
    unique case (mode_i)
      RATIO_256: en_o = run_i;
      RATIO_384: en_o = run_i & (ph_q != 2'd2);
      RATIO_512: en_o = run_i & (ph_q == 2'd0);
      default:   en_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/sync_ctrl.sv
module sync_ctrl
  import clkmon_pkg::*;
#(
  parameter int BASE  = 256,
  parameter int TOL   = 2,
  parameter int DRIFT = 24,
  parameter int HOLD  = 32,
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             meas_vld_i,
  input  logic [CNT_W-1:0] meas_len_i,
  input  logic             en_i,
  output ratio_e           lock_ratio_o,
  output logic [1:0]       ratio_o,
  output logic             locked_o,
  output logic             mute_o
);

  localparam int TW = $clog2(2 * BASE) + 1;
  localparam int HW = $clog2(HOLD);
  localparam logic [TW:0]   TICK_HI  = (TW + 1)'(BASE + DRIFT);
  localparam logic [TW:0]   TICK_LO  = (TW + 1)'(BASE - DRIFT);
  localparam logic [HW-1:0] HOLD_END = HW'(HOLD - 1);
  localparam logic [TW-1:0] TICK_MAX = '1;

  sync_st_e      st_q;
  ratio_e        cand_q, last_q, lock_q, cls;
  logic [TW-1:0] tick_q;
  logic [TW:0]   tick_fin;
  logic [HW-1:0] hold_q;
  logic          in_lock, dev_bad, overrun, loss;

  assign cls      = classify(32'(meas_len_i), 32'(BASE), 32'(TOL));
  assign in_lock  = (st_q != ST_ACQ);
  assign tick_fin = {1'b0, tick_q} + (TW + 1)'(en_i);
  assign dev_bad  = (tick_fin > TICK_HI) || (tick_fin < TICK_LO);
  assign overrun  = ({1'b0, tick_q} > TICK_HI);
  assign loss     = in_lock & ((edge_i & dev_bad) | overrun);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      last_q <= RATIO_NONE;
    end else begin
      if (edge_i)                          tick_q <= '0;
      else if (en_i && tick_q != TICK_MAX) tick_q <= tick_q + 1'b1;
      if (meas_vld_i) last_q <= cls;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACQ;
      cand_q <= RATIO_NONE;
      lock_q <= RATIO_NONE;
      hold_q <= '0;
    end else begin
      unique case (st_q)
        ST_ACQ: begin
          if (meas_vld_i) begin
            cand_q <= cls;
            if (cls != RATIO_NONE && cls == cand_q) begin
              st_q   <= ST_HOLD;
              lock_q <= cls;
              hold_q <= '0;
            end
          end
        end
        ST_HOLD, ST_RUN: begin
          if (loss) begin
            st_q   <= ST_ACQ;
            cand_q <= RATIO_NONE;
          end else if (edge_i && st_q == ST_HOLD) begin
            if (hold_q == HOLD_END) st_q <= ST_RUN;
            else                    hold_q <= hold_q + 1'b1;
          end
        end
        default: st_q <= ST_ACQ;
      endcase
    end
  end

  assign lock_ratio_o = lock_q;
  assign locked_o     = in_lock;
  assign mute_o       = (st_q != ST_RUN);
  assign ratio_o      = in_lock ? lock_q : last_q;

endmodule

// File: rtl/clk_ratio_sync_mon.sv
module clk_ratio_sync_mon
  import clkmon_pkg::*;
#(
  parameter int BASE   = 256,
  parameter int TOL    = 2,
  parameter int DRIFT  = 24,
  parameter int HOLD   = 32,
  parameter int SYNC_N = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wclk_i,
  output logic [1:0] ratio_o,
  output logic       en256_o,
  output logic       locked_o,
  output logic       mute_o
);

  localparam int CNT_W = $clog2(4 * BASE);

  logic             wedge, meas_vld;
  logic [CNT_W-1:0] meas_len;
  ratio_e           lock_ratio;

  wclk_meter #(.SYNC_N(SYNC_N), .CNT_W(CNT_W)) u_meter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wclk_i     (wclk_i),
    .edge_o     (wedge),
    .meas_vld_o (meas_vld),
    .meas_len_o (meas_len)
  );

  clk_en_gen u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (wedge),
    .run_i  (locked_o),
    .mode_i (lock_ratio),
    .en_o   (en256_o)
  );

  sync_ctrl #(
    .BASE(BASE), .TOL(TOL), .DRIFT(DRIFT), .HOLD(HOLD), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .edge_i       (wedge),
    .meas_vld_i   (meas_vld),
    .meas_len_i   (meas_len),
    .en_i         (en256_o),
    .lock_ratio_o (lock_ratio),
    .ratio_o      (ratio_o),
    .locked_o     (locked_o),
    .mute_o       (mute_o)
  );

endmodule

// File: rtl/clk_ratio_sync_mon_chk.sv
module clk_ratio_sync_mon_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] ratio_o,
  input logic       en256_o,
  input logic       locked_o,
  input logic       mute_o
);

  p_mute_unlocked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> mute_o);

  p_no_en_unlocked_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_o |-> !en256_o);

  p_full_rate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && ratio_o == 2'b01) |-> en256_o);

  p_ratio_code_locked_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |-> (ratio_o != 2'b00));

  p_ratio_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(ratio_o));

  p_lock_starts_muted_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> mute_o);

  p_unmute_locked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mute_o) |-> locked_o);

endmodule

bind clk_ratio_sync_mon clk_ratio_sync_mon_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ratio_o  (ratio_o),
  .en256_o  (en256_o),
  .locked_o (locked_o),
  .mute_o   (mute_o)
);

// File: tb/sim_clk_ratio_sync_mon.sv
module sim_clk_ratio_sync_mon;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wclk_i = 1'b0;
  logic [1:0] ratio_o;
  logic       en256_o, locked_o, mute_o;

  int checks = 0;
  int errors = 0;
  int en_cnt = 0;

  always #2 clk_i = ~clk_i;

  clk_ratio_sync_mon u0 (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wclk_i   (wclk_i),
    .ratio_o  (ratio_o),
    .en256_o  (en256_o),
    .locked_o (locked_o),
    .mute_o   (mute_o)
  );

  typedef struct packed {
    logic [15:0] period;
    logic [7:0]  nfr;
    logic [1:0]  ratio;
    logic        lk;
    logic        mu;
  } vec_t;

  // period, frames, expected ratio, locked, mute (checked after a fresh reset)
  localparam vec_t VEC [14] = '{
    '{16'd256, 8'd3,  2'b01, 1'b1, 1'b1},
    '{16'd256, 8'd2,  2'b01, 1'b0, 1'b1},
    '{16'd384, 8'd3,  2'b10, 1'b1, 1'b1},
    '{16'd512, 8'd3,  2'b11, 1'b1, 1'b1},
    '{16'd256, 8'd35, 2'b01, 1'b1, 1'b0},
    '{16'd256, 8'd34, 2'b01, 1'b1, 1'b1},
    '{16'd258, 8'd3,  2'b01, 1'b1, 1'b1},
    '{16'd259, 8'd3,  2'b00, 1'b0, 1'b1},
    '{16'd382, 8'd3,  2'b10, 1'b1, 1'b1},
    '{16'd381, 8'd3,  2'b00, 1'b0, 1'b1},
    '{16'd514, 8'd3,  2'b11, 1'b1, 1'b1},
    '{16'd515, 8'd3,  2'b00, 1'b0, 1'b1},
    '{16'd300, 8'd6,  2'b00, 1'b0, 1'b1},
    '{16'd512, 8'd36, 2'b11, 1'b1, 1'b0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic frame(input int p);
    en_cnt = 0;
    for (int i = 0; i < p; i++) begin
      @(negedge clk_i);
      if (en256_o) en_cnt++;
      wclk_i = (i < p / 2);
    end
  endtask

  task automatic frames(input int p, input int n);
    for (int k = 0; k < n; k++) frame(p);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    wclk_i = 1'b0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic expect_state(input string tag, input logic [1:0] r, input logic lk,
                              input logic mu);
    chk(ratio_o == r,   {tag, " ratio"},  int'(ratio_o),  int'(r));
    chk(locked_o == lk, {tag, " locked"}, int'(locked_o), int'(lk));
    chk(mute_o == mu,   {tag, " mute"},   int'(mute_o),   int'(mu));
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8 reset state, during reset and just after release
    repeat (3) @(negedge clk_i);
    expect_state("R8 in reset", 2'b00, 1'b0, 1'b1);
    chk(en256_o == 1'b0, "R8 en in reset", int'(en256_o), 0);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk_i);
    expect_state("R8 after release", 2'b00, 1'b0, 1'b1);
    chk(en256_o == 1'b0, "R8 en after release", int'(en256_o), 0);

    // R1/R2/R4/R9 vector walk
    for (int v = 0; v < 14; v++) begin
      do_reset();
      frames(int'(VEC[v].period), int'(VEC[v].nfr));
      expect_state($sformatf("R1/R2/R4/R9 row %0d", v), VEC[v].ratio, VEC[v].lk, VEC[v].mu);
    end

    // R3 enable density per word period in each ratio
    do_reset();
    frames(256, 36);
    frame(256);
    chk(en_cnt == 256, "R3 en count 256x", en_cnt, 256);
    do_reset();
    frames(384, 5);
    frame(384);
    chk(en_cnt == 256, "R3 en count 384x", en_cnt, 256);
    do_reset();
    frames(512, 5);
    frame(512);
    chk(en_cnt == 256, "R3 en count 512x", en_cnt, 256);
    do_reset();
    frames(300, 4);
    frame(300);
    chk(en_cnt == 0, "R9 no enables when invalid", en_cnt, 0);

    // R5/R6/R7 drift handling from the unmuted state
    do_reset();
    frames(256, 36);
    frame(272);
    frame(256);
    chk(locked_o && !mute_o, "R5 drift of 16 ticks kept", int'({locked_o, mute_o}), 2);
    frame(288);
    chk(!locked_o && mute_o, "R6 long period loss before end", int'({locked_o, mute_o}), 1);
    frames(256, 5);
    expect_state("R7 relock muted", 2'b01, 1'b1, 1'b1);
    frames(256, 31);
    chk(!mute_o, "R7 mute released after hold", int'(mute_o), 0);
    frame(224);
    frame(256);
    chk(!locked_o && mute_o, "R6 short period loss", int'({locked_o, mute_o}), 1);

    // R7 ratio change 256x to 512x
    do_reset();
    frames(256, 36);
    frame(512);
    chk(!locked_o, "R6 overrun on ratio jump", int'(locked_o), 0);
    frames(512, 2);
    expect_state("R7 relock at 512x", 2'b11, 1'b1, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule